// File: doc/BRIEF.md
# Byte-Memory DMA Controller

This block moves words between an external memory that is only one byte wide and the on-chip program or data memory. Software programs a format code, a direction, a hold flag, an on-chip start address, a page number with an in-page byte offset, and a wait-state count. Writing a nonzero word count then starts the transfer. For each word the block makes one to three byte accesses on the external bus. It packs the bytes into a 24-bit or 16-bit word, or into one byte lane of a data word, and stores that word into on-chip memory in a single cycle. In the other direction it reads one word and sends its bytes out.

The external byte address is the page and the offset joined into one 22-bit pointer, so a run of bytes crosses from one page into the next without help from software. A processor request for the external bus takes priority over any byte access that has not yet begun. With the hold flag set, the processor is stalled for the whole run and told to restart from address zero at the end. A boot preset, sampled while reset is active, loads a 32-word program-memory fetch with the hold flag set, so the first block of code loads by itself as reset is released.

Top module: `byte_dma_top`

## Requirements
- R1: Format code 00 (CTRL bits [1:0]) reads three bytes per word, most significant first, and stores the 24-bit word to program memory (memSpace = 0).
- R2: Format code 01 reads two bytes per word, the first into bits [15:8] and the second into bits [7:0], and stores the word to data memory (memSpace = 1) with bits [23:16] zero.
- R3: Format 10 places one byte in bits [15:8] and format 11 places one byte in bits [7:0] of a data-memory word. All other bits are zero.
- R4: The external address is {page, offset} on 22 bits. It starts at the programmed value and rises by one per byte access, carrying from the offset into the page.
- R5: Writing a nonzero value to COUNT (select 4) while idle starts a run, and writing zero starts nothing. COUNT falls by one per word and reads zero at the end. doneIrq then pulses for exactly one cycle. After a plain reset COUNT reads zero, and no strobe, hold or interrupt is active.
- R6: Every byte access holds its read or write strobe for WAIT+1 cycles, where WAIT is the value written to select 5.
- R7: While cpuExtReq is high, no new byte access begins. The run resumes once the request drops.
- R8: With the hold flag (CTRL bit 3) set, cpuHold is high during every byte access, and cpuRestart pulses together with doneIrq. With the flag clear, neither is ever asserted.
- R9: With bootPreset high during reset, CTRL reads 4'b1000 (format 00, direction 0, hold 1) and PAGE, EXT and INT read 0. COUNT reads 32, and a 32-word load runs once reset is released.
- R10: Writes to PAGE (select 1) and EXT (select 2) while a run is active are ignored. The pointer keeps advancing from its programmed value.
- R11: With the direction bit (CTRL bit 2) set, each word is read from on-chip memory and its bytes are written out in the lane order of R1 to R3, using extWrEn in place of extRdEn.
- R12: The on-chip address starts at INT (select 3) and rises by one per word in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| bootPreset | input | 1 | Selects boot defaults while reset is active |
| regWe | input | 1 | Register write strobe |
| regSel | input | 3 | Register select (0 CTRL, 1 PAGE, 2 EXT, 3 INT, 4 COUNT, 5 WAIT) |
| regWdata | input | 14 | Register write data |
| regRdata | output | 14 | Read-back of the selected register |
| cpuExtReq | input | 1 | Processor request for the external bus |
| extAddr | output | 22 | Byte-memory address {page, offset} |
| extRdEn | output | 1 | Byte read strobe |
| extWrEn | output | 1 | Byte write strobe |
| extWdata | output | 8 | Byte write data |
| extRdata | input | 8 | Byte read data, sampled on the last strobe cycle |
| memAddr | output | 14 | On-chip word address |
| memSpace | output | 1 | 0 program memory, 1 data memory |
| memWe | output | 1 | On-chip word write |
| memRe | output | 1 | On-chip word read, data due the next cycle |
| memWdata | output | 24 | On-chip write word |
| memRdata | input | 24 | On-chip read word |
| doneIrq | output | 1 | One-cycle completion pulse |
| cpuHold | output | 1 | Processor hold during a run with the hold flag |
| cpuRestart | output | 1 | Restart-at-zero pulse at the end of a held run |

## Verification
The sweep covers all four format codes in both directions, each at two wait-state settings. Byte data is a function of the external address and word data is a function of the on-chip address, so a misplaced lane, a swapped byte order or a skipped address each produce a different word. The outbound runs start just below a page end, which separates a true 22-bit carry from a wrap inside the page. Separate runs cover the boot preset, a zero count, writes to the pointers during a run, and a bus request held across a run, each compared against arithmetic expectations.

// File: rtl/bdx_pkg.sv
`timescale 1ns/1ps
package bdx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_LATCH,
    ST_BYTE,
    ST_STORE
  } xferStateT;

  // strobes from control to datapath
  typedef struct packed {
    logic start;
    logic fetch;
    logic latchWord;
    logic byteDone;
    logic wordDone;
  } dpStrobeT;

  localparam logic [2:0] SEL_CTRL  = 3'd0;
  localparam logic [2:0] SEL_PAGE  = 3'd1;
  localparam logic [2:0] SEL_EXT   = 3'd2;
  localparam logic [2:0] SEL_INT   = 3'd3;
  localparam logic [2:0] SEL_COUNT = 3'd4;
  localparam logic [2:0] SEL_WAIT  = 3'd5;

  localparam logic [1:0] FMT_PM24  = 2'b00;
  localparam logic [1:0] FMT_DM16  = 2'b01;
  localparam logic [1:0] FMT_DM8HI = 2'b10;
  localparam logic [1:0] FMT_DM8LO = 2'b11;

  // index of the final byte of a word for a format
  function automatic logic [1:0] lastIndex(input logic [1:0] fmt);
    case (fmt)
      FMT_PM24: return 2'd2;
      FMT_DM16: return 2'd1;
      default:  return 2'd0;
    endcase
  endfunction

  // byte lane (0 = bits 7:0) used by byte number idx of a word
  function automatic logic [1:0] laneOf(input logic [1:0] fmt, input logic [1:0] idx);
    case (fmt)
      FMT_PM24:  return 2'd2 - idx;
      FMT_DM16:  return 2'd1 - idx;
      FMT_DM8HI: return 2'd1;
      default:   return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/bdx_datapath.sv
`timescale 1ns/1ps
module bdx_datapath
  import bdx_pkg::*;
#(
  parameter int OFF_W      = 14,
  parameter int PAGE_W     = 8,
  parameter int CNT_W      = 14,
  parameter int WAIT_W     = 3,
  parameter int BOOT_COUNT = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    bootPreset,
  input  logic                    busy,
  input  dpStrobeT                stb,
  input  logic                    regWe,
  input  logic [2:0]              regSel,
  input  logic [CNT_W-1:0]        regWdata,
  output logic [CNT_W-1:0]        regRdata,
  output logic                    startReq,
  output logic                    dirOut,
  output logic                    haltOut,
  output logic                    lastByte,
  output logic                    lastWord,
  output logic [WAIT_W-1:0]       waitStates,
  output logic [PAGE_W+OFF_W-1:0] extAddr,
  output logic [7:0]              extWdata,
  input  logic [7:0]              extRdata,
  output logic [OFF_W-1:0]        memAddr,
  output logic                    memSpace,
  output logic                    memWe,
  output logic                    memRe,
  output logic [23:0]             memWdata,
  input  logic [23:0]             memRdata
);

  localparam int EXT_W = PAGE_W + OFF_W;

  logic [1:0]       fmt;
  logic             dir;
  logic             halt;
  logic [EXT_W-1:0] extPtr;
  logic [OFF_W-1:0] intPtr;
  logic [CNT_W-1:0] count;
  logic [23:0]      wordReg;
  logic [1:0]       byteIdx;
  logic [1:0]       lane;
  logic [23:0]      mergedWord;
  logic [7:0]       laneByte;

  assign lane = laneOf(fmt, byteIdx);

  // insert the incoming byte into its lane
  always_comb begin
    mergedWord = wordReg;
    case (lane)
      2'd0:    mergedWord[7:0]   = extRdata;
      2'd1:    mergedWord[15:8]  = extRdata;
      default: mergedWord[23:16] = extRdata;
    endcase
  end

  // pick the outgoing byte from its lane
  always_comb begin
    case (lane)
      2'd0:    laneByte = wordReg[7:0];
      2'd1:    laneByte = wordReg[15:8];
      default: laneByte = wordReg[23:16];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fmt        <= FMT_PM24;
      dir        <= 1'b0;
      halt       <= bootPreset;
      extPtr     <= '0;
      intPtr     <= '0;
      waitStates <= '0;
      count      <= bootPreset ? CNT_W'(BOOT_COUNT) : '0;
      wordReg    <= '0;
      byteIdx    <= '0;
    end else begin
      if (regWe && regSel == SEL_WAIT)
        waitStates <= regWdata[WAIT_W-1:0];
      if (regWe && !busy) begin
        case (regSel)
          SEL_CTRL:  {halt, dir, fmt} <= regWdata[3:0];
          SEL_PAGE:  extPtr[EXT_W-1:OFF_W] <= regWdata[PAGE_W-1:0];
          SEL_EXT:   extPtr[OFF_W-1:0] <= regWdata[OFF_W-1:0];
          SEL_INT:   intPtr <= regWdata[OFF_W-1:0];
          SEL_COUNT: count <= regWdata;
          default: ;
        endcase
      end
      if (stb.start) begin
        byteIdx <= '0;
        wordReg <= '0;
      end
      if (stb.latchWord)
        wordReg <= memRdata;
      if (stb.byteDone) begin
        if (!dir)
          wordReg <= mergedWord;
        extPtr  <= extPtr + 1'b1;
        byteIdx <= byteIdx + 1'b1;
      end
      if (stb.wordDone) begin
        intPtr  <= intPtr + 1'b1;
        count   <= count - 1'b1;
        byteIdx <= '0;
      end
    end
  end

  always_comb begin
    case (regSel)
      SEL_CTRL:  regRdata = CNT_W'({halt, dir, fmt});
      SEL_PAGE:  regRdata = CNT_W'(extPtr[EXT_W-1:OFF_W]);
      SEL_EXT:   regRdata = CNT_W'(extPtr[OFF_W-1:0]);
      SEL_INT:   regRdata = CNT_W'(intPtr);
      SEL_COUNT: regRdata = count;
      SEL_WAIT:  regRdata = CNT_W'(waitStates);
      default:   regRdata = '0;
    endcase
  end

  assign startReq = regWe && !busy && regSel == SEL_COUNT && (regWdata != '0);
  assign dirOut   = dir;
  assign haltOut  = halt;
  assign lastByte = (byteIdx == lastIndex(fmt));
  assign lastWord = (count == CNT_W'(1));
  assign extAddr  = extPtr;
  assign extWdata = laneByte;
  assign memAddr  = intPtr;
  assign memSpace = (fmt != FMT_PM24);
  assign memWe    = stb.wordDone && !dir;
  assign memRe    = stb.fetch;
  assign memWdata = wordReg;

endmodule

// File: rtl/bdx_ctrl.sv
`timescale 1ns/1ps
module bdx_ctrl
  import bdx_pkg::*;
#(
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bootPreset,
  input  logic              cpuExtReq,
  input  logic              startReq,
  input  logic              dir,
  input  logic              halt,
  input  logic              lastByte,
  input  logic              lastWord,
  input  logic [WAIT_W-1:0] waitStates,
  output dpStrobeT          stb,
  output logic              busy,
  output logic              extRdEn,
  output logic              extWrEn,
  output logic              doneIrq,
  output logic              cpuHold,
  output logic              cpuRestart
);

  xferStateT         state;
  logic              inAccess;
  logic [WAIT_W-1:0] waitCnt;
  logic              accessEnd;
  logic              finish;

  assign accessEnd = (state == ST_BYTE) && inAccess && (waitCnt == '0);

  always_comb begin
    stb = '0;
    case (state)
      ST_IDLE:  stb.start     = startReq;
      ST_FETCH: stb.fetch     = 1'b1;
      ST_LATCH: stb.latchWord = 1'b1;
      ST_BYTE: begin
        stb.byteDone = accessEnd;
        stb.wordDone = accessEnd && lastByte && dir;
      end
      ST_STORE: stb.wordDone = 1'b1;
      default: ;
    endcase
  end

  assign finish = stb.wordDone && lastWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= bootPreset ? ST_BYTE : ST_IDLE;
      busy       <= bootPreset;
      inAccess   <= 1'b0;
      waitCnt    <= '0;
      doneIrq    <= 1'b0;
      cpuRestart <= 1'b0;
    end else begin
      doneIrq    <= finish;
      cpuRestart <= finish && halt;
      if (finish)
        busy <= 1'b0;
      case (state)
        ST_IDLE: if (startReq) begin
          busy  <= 1'b1;
          state <= dir ? ST_FETCH : ST_BYTE;
        end
        ST_FETCH: state <= ST_LATCH;
        ST_LATCH: state <= ST_BYTE;
        ST_BYTE: begin
          if (!inAccess) begin
            if (!cpuExtReq) begin
              inAccess <= 1'b1;
              waitCnt  <= waitStates;
            end
          end else if (waitCnt == '0) begin
            inAccess <= 1'b0;
            if (lastByte) begin
              if (dir)
                state <= lastWord ? ST_IDLE : ST_FETCH;
              else
                state <= ST_STORE;
            end
          end else begin
            waitCnt <= waitCnt - 1'b1;
          end
        end
        ST_STORE: state <= lastWord ? ST_IDLE : ST_BYTE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign extRdEn = inAccess && !dir;
  assign extWrEn = inAccess && dir;
  assign cpuHold = busy && halt;

endmodule

// File: rtl/byte_dma_top.sv
`timescale 1ns/1ps
module byte_dma_top
  import bdx_pkg::*;
#(
  parameter int OFF_W      = 14,
  parameter int PAGE_W     = 8,
  parameter int CNT_W      = 14,
  parameter int WAIT_W     = 3,
  parameter int BOOT_COUNT = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    bootPreset,
  input  logic                    regWe,
  input  logic [2:0]              regSel,
  input  logic [CNT_W-1:0]        regWdata,
  output logic [CNT_W-1:0]        regRdata,
  input  logic                    cpuExtReq,
  output logic [PAGE_W+OFF_W-1:0] extAddr,
  output logic                    extRdEn,
  output logic                    extWrEn,
  output logic [7:0]              extWdata,
  input  logic [7:0]              extRdata,
  output logic [OFF_W-1:0]        memAddr,
  output logic                    memSpace,
  output logic                    memWe,
  output logic                    memRe,
  output logic [23:0]             memWdata,
  input  logic [23:0]             memRdata,
  output logic                    doneIrq,
  output logic                    cpuHold,
  output logic                    cpuRestart
);

  dpStrobeT          stb;
  logic              busy;
  logic              startReq;
  logic              dir;
  logic              halt;
  logic              lastByte;
  logic              lastWord;
  logic [WAIT_W-1:0] waitStates;

  bdx_ctrl #(.WAIT_W(WAIT_W)) ctrl (
    .clk(clk), .rstN(rstN), .bootPreset(bootPreset), .cpuExtReq(cpuExtReq),
    .startReq(startReq), .dir(dir), .halt(halt), .lastByte(lastByte),
    .lastWord(lastWord), .waitStates(waitStates), .stb(stb), .busy(busy),
    .extRdEn(extRdEn), .extWrEn(extWrEn), .doneIrq(doneIrq),
    .cpuHold(cpuHold), .cpuRestart(cpuRestart)
  );

  bdx_datapath #(
    .OFF_W(OFF_W), .PAGE_W(PAGE_W), .CNT_W(CNT_W),
    .WAIT_W(WAIT_W), .BOOT_COUNT(BOOT_COUNT)
  ) dp (
    .clk(clk), .rstN(rstN), .bootPreset(bootPreset), .busy(busy), .stb(stb),
    .regWe(regWe), .regSel(regSel), .regWdata(regWdata), .regRdata(regRdata),
    .startReq(startReq), .dirOut(dir), .haltOut(halt), .lastByte(lastByte),
    .lastWord(lastWord), .waitStates(waitStates), .extAddr(extAddr),
    .extWdata(extWdata), .extRdata(extRdata), .memAddr(memAddr),
    .memSpace(memSpace), .memWe(memWe), .memRe(memRe),
    .memWdata(memWdata), .memRdata(memRdata)
  );

endmodule

// File: rtl/bdx_checker.sv
`timescale 1ns/1ps
module bdx_checker (
  input logic clk,
  input logic rstN,
  input logic cpuExtReq,
  input logic extRdEn,
  input logic extWrEn,
  input logic memWe,
  input logic doneIrq,
  input logic cpuHold,
  input logic cpuRestart
);

  a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !(extRdEn && extWrEn));

  a_r7_req_blocks_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(extRdEn || extWrEn) |-> !$past(cpuExtReq));

  a_r5_single_irq: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |=> !doneIrq);

  a_r8_hold_released: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |-> !cpuHold);

  a_r8_restart_at_done: assert property (@(posedge clk) disable iff (!rstN)
    cpuRestart |-> doneIrq);

  a_r1_store_off_bus: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> !(extRdEn || extWrEn));

endmodule

bind byte_dma_top bdx_checker chk (.*);

// File: tb/byte_dma_top_test.sv
`timescale 1ns/1ps
module byte_dma_top_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bootPreset = 1'b0;
  logic        regWe = 1'b0;
  logic [2:0]  regSel = 3'd0;
  logic [13:0] regWdata = '0;
  logic [13:0] regRdata;
  logic        cpuExtReq = 1'b0;
  logic [21:0] extAddr;
  logic        extRdEn, extWrEn;
  logic [7:0]  extWdata, extRdata;
  logic [13:0] memAddr;
  logic        memSpace, memWe, memRe;
  logic [23:0] memWdata;
  logic [23:0] memRdata = '0;
  logic        doneIrq, cpuHold, cpuRestart;

  always #4 clk = ~clk;

  byte_dma_top uut (
    .clk(clk), .rstN(rstN), .bootPreset(bootPreset), .regWe(regWe),
    .regSel(regSel), .regWdata(regWdata), .regRdata(regRdata),
    .cpuExtReq(cpuExtReq), .extAddr(extAddr), .extRdEn(extRdEn),
    .extWrEn(extWrEn), .extWdata(extWdata), .extRdata(extRdata),
    .memAddr(memAddr), .memSpace(memSpace), .memWe(memWe), .memRe(memRe),
    .memWdata(memWdata), .memRdata(memRdata), .doneIrq(doneIrq),
    .cpuHold(cpuHold), .cpuRestart(cpuRestart)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  function automatic logic [7:0] bytePat(input logic [21:0] a);
    logic [7:0] r;
    r = a[7:0] + (a[15:8] * 8'd3) + {2'b00, a[21:16]};
    return r;
  endfunction

  function automatic logic [23:0] intPat(input logic [13:0] a);
    return {a[7:0] ^ 8'h5A, a[7:0] + 8'd17, ~a[7:0]};
  endfunction

  function automatic int nbOf(input int fmt);
    return (fmt == 0) ? 3 : (fmt == 1) ? 2 : 1;
  endfunction

  function automatic logic [23:0] expWord(input int fmt, input logic [21:0] b);
    logic [7:0] b0, b1, b2;
    b0 = bytePat(b);
    b1 = bytePat(b + 22'd1);
    b2 = bytePat(b + 22'd2);
    case (fmt)
      0: return {b0, b1, b2};
      1: return {8'h00, b0, b1};
      2: return {8'h00, b0, 8'h00};
      default: return {16'h0000, b0};
    endcase
  endfunction

  function automatic logic [7:0] expOut(input int fmt, input logic [23:0] w, input int k);
    case (fmt)
      0: return (k == 0) ? w[23:16] : (k == 1) ? w[15:8] : w[7:0];
      1: return (k == 0) ? w[15:8] : w[7:0];
      2: return w[15:8];
      default: return w[7:0];
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // on-chip memory model: one-cycle read
  always @(posedge clk) if (memRe) memRdata <= intPat(memAddr);
  assign extRdata = bytePat(extAddr);

  // monitor expectations
  int          mFmt = 0, mDir = 0, mHalt = 0, mWait = 0;
  logic [13:0] mInt = '0;
  logic [21:0] mExt = '0;
  int wordCnt = 0, rdCnt = 0, byteCnt = 0, strobeLen = 0;
  int irqCnt = 0, restartCnt = 0, holdSeen = 0;
  bit prevStrobe = 0, prevReq = 0;

  always @(negedge clk) begin
    if (rstN) begin
      int nb;
      bit s;
      nb = nbOf(mFmt);
      s = extRdEn || extWrEn;
      if (memWe) begin
        chk(memAddr == mInt + 14'(wordCnt), "R12 store address", memAddr, mInt + 14'(wordCnt));
        chk(memSpace == (mFmt != 0), "R1 R2 memory space", memSpace, (mFmt != 0));
        chk(memWdata == expWord(mFmt, mExt + 22'(wordCnt * nb)),
            (mFmt == 0) ? "R1 word" : (mFmt == 1) ? "R2 word" : "R3 word",
            memWdata, expWord(mFmt, mExt + 22'(wordCnt * nb)));
        wordCnt++;
      end
      if (memRe) begin
        chk(memAddr == mInt + 14'(rdCnt), "R12 fetch address", memAddr, mInt + 14'(rdCnt));
        rdCnt++;
      end
      if (s && !prevStrobe) begin
        chk(extAddr == mExt + 22'(byteCnt), "R4 byte address", extAddr, mExt + 22'(byteCnt));
        chk(extWrEn == (mDir != 0), "R11 direction", extWrEn, (mDir != 0));
        chk(!prevReq, "R7 start under request", prevReq, 0);
        if (mHalt != 0) chk(cpuHold, "R8 hold during access", cpuHold, 1);
        if (extWrEn)
          chk(extWdata == expOut(mFmt, intPat(mInt + 14'(byteCnt / nb)), byteCnt % nb),
              "R11 out byte", extWdata,
              expOut(mFmt, intPat(mInt + 14'(byteCnt / nb)), byteCnt % nb));
        strobeLen = 1;
      end else if (s) begin
        strobeLen++;
      end
      if (!s && prevStrobe) begin
        chk(strobeLen == mWait + 1, "R6 strobe length", strobeLen, mWait + 1);
        byteCnt++;
      end
      if (doneIrq) irqCnt++;
      if (cpuRestart) restartCnt++;
      if (cpuHold) holdSeen++;
      prevStrobe = s;
      prevReq = cpuExtReq;
    end
  end

  task automatic wr(input logic [2:0] s, input logic [13:0] d);
    @(posedge clk); #1;
    regWe = 1'b1; regSel = s; regWdata = d;
    @(posedge clk); #1;
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [13:0] v);
    regSel = s;
    #1;
    v = regRdata;
  endtask

  task automatic setMon(input int fmt, input int dir, input int halt, input int wt,
                        input logic [13:0] intB, input logic [21:0] extB);
    mFmt = fmt; mDir = dir; mHalt = halt; mWait = wt; mInt = intB; mExt = extB;
    wordCnt = 0; rdCnt = 0; byteCnt = 0; irqCnt = 0; restartCnt = 0; holdSeen = 0;
  endtask

  task automatic startXfer(input int fmt, input int dir, input int halt, input logic [13:0] intB,
                           input logic [7:0] page, input logic [13:0] ext, input int wt, input int n);
    setMon(fmt, dir, halt, wt, intB, {page, ext});
    wr(3'd0, 14'({halt[0], dir[0], fmt[1:0]}));
    wr(3'd1, {6'd0, page});
    wr(3'd2, ext);
    wr(3'd3, intB);
    wr(3'd5, 14'(wt));
    wr(3'd4, 14'(n));
  endtask

  task automatic finishXfer(input int n);
    logic [13:0] v;
    for (int i = 0; i < 20000 && irqCnt == 0; i++) @(posedge clk);
    repeat (3) @(posedge clk);
    #1;
    chk(irqCnt == 1, "R5 one done pulse", irqCnt, 1);
    chk(byteCnt == n * nbOf(mFmt), "R4 byte count", byteCnt, n * nbOf(mFmt));
    if (mDir != 0) chk(rdCnt == n, "R12 words fetched", rdCnt, n);
    else           chk(wordCnt == n, "R12 words stored", wordCnt, n);
    rd(3'd4, v);
    chk(v == 14'd0, "R5 count at end", v, 0);
    chk(restartCnt == mHalt, "R8 restart pulses", restartCnt, mHalt);
    chk((holdSeen > 0) == (mHalt != 0), "R8 hold seen", holdSeen, mHalt);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [13:0] v;
    // plain reset state (R5)
    repeat (3) @(posedge clk);
    #1;
    rd(3'd4, v);
    chk(v == 14'd0, "R5 reset count", v, 0);
    chk(!cpuHold && !doneIrq && !extRdEn && !extWrEn && !memWe, "R5 reset idle",
        {cpuHold, doneIrq, extRdEn, extWrEn, memWe}, 0);

    // boot preset (R9)
    bootPreset = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    rd(3'd4, v); chk(v == 14'd32, "R9 boot count", v, 32);
    rd(3'd0, v); chk(v == 14'h8, "R9 boot ctrl", v, 8);
    rd(3'd1, v); chk(v == 14'd0, "R9 boot page", v, 0);
    rd(3'd2, v); chk(v == 14'd0, "R9 boot ext", v, 0);
    rd(3'd3, v); chk(v == 14'd0, "R9 boot int", v, 0);
    chk(cpuHold, "R9 boot hold", cpuHold, 1);
    setMon(0, 0, 1, 0, 14'd0, 22'd0);
    rstN = 1'b1;
    bootPreset = 1'b0;
    finishXfer(32);

    // zero count starts nothing (R5)
    setMon(1, 0, 0, 0, 14'd0, 22'd0);
    wr(3'd0, 14'h1);
    wr(3'd4, 14'd0);
    repeat (20) @(posedge clk);
    #1;
    chk(byteCnt == 0 && irqCnt == 0 && !cpuHold, "R5 zero count idle", byteCnt + irqCnt, 0);

    // sweep of formats, directions and wait states
    for (int fmt = 0; fmt < 4; fmt++)
      for (int dir = 0; dir < 2; dir++)
        for (int w = 0; w < 2; w++) begin
          startXfer(fmt, dir, (fmt == 2) ? 1 : 0, 14'(16 + fmt * 8), 8'(fmt + 1),
                    (dir != 0) ? 14'h3FFE : 14'h0100, w * 2, 3);
          finishXfer(3);
        end

    // pointer writes ignored while active (R10)
    startXfer(1, 0, 0, 14'h50, 8'd7, 14'h3FFC, 3, 4);
    repeat (5) @(posedge clk);
    wr(3'd1, 14'hFF);
    wr(3'd2, 14'h1234);
    finishXfer(4);
    rd(3'd2, v); chk(v == 14'h0004, "R10 ext pointer kept", v, 4);
    rd(3'd1, v); chk(v == 14'h0008, "R10 page kept", v, 8);

    // external bus request stalls (R7)
    begin
      int snap;
      startXfer(0, 0, 0, 14'h40, 8'd2, 14'h0010, 1, 2);
      repeat (4) @(posedge clk);
      #1 cpuExtReq = 1'b1;
      repeat (5) @(posedge clk);
      #1 snap = byteCnt;
      repeat (30) @(posedge clk);
      #1;
      chk(byteCnt == snap, "R7 stalled under request", byteCnt, snap);
      chk(!extRdEn, "R7 no strobe under request", extRdEn, 0);
      cpuExtReq = 1'b0;
      finishXfer(2);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule